// File: doc/BRIEF.md
# Power-Domain Gate Sequencer

This block sequences the power switch and the clock gate of one power domain. A small state machine walks the domain through four phases: unpowered, rail ramping, running and clock-parked. It drives two enables from those phases, so that the domain clock can only run once the rail has been reported stable.

Each clock cycle the controller samples one encoded event. The event is a power-on request, a rail-ready indication, a sleep request, a power-off request or nothing. The controller takes at most one step along a fixed one-way ring and never skips a phase. Both enables come straight from the state register, so they change together on the same edge as the state. The current state is also brought out, so that the surrounding power-management logic can observe the phase.

Top module: `pgs_seq`

## Requirements
- R1: While rst_ni is low, the state is forced to the unpowered phase (state_o = 2'b00), with pwr_en_o and clk_en_o both low.
- R2: pwr_en_o is low in the unpowered phase and high in the other three phases.
- R3: clk_en_o is high only in the running phase (state_o = 2'b10) and low in the other three phases.
- R4: From unpowered (00), a power-on event (evt_i = 1) moves to ramping (01). From ramping, a rail-ready event (evt_i = 2) moves to running (10). Each move happens on the next rising edge.
- R5: From running (10), a sleep event (evt_i = 3) moves to clock-parked (11). From clock-parked, a power-off event (evt_i = 4) moves to unpowered (00).
- R6: Every other pairing of state and event leaves the state unchanged, including the no-op event (evt_i = 0). In particular, parked never returns to running, and running never jumps to unpowered.
- R7: Event codes 5, 6 and 7 have the same effect as the no-op code in every state.
- R8: In every cycle, pwr_en_o low implies clk_en_o low.
- R9: state_o uses the encoding unpowered = 00, ramping = 01, running = 10, parked = 11. Both enables change on the same clock edge as state_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | EVT_W (3) | Encoded event: 0 none, 1 power-on, 2 rail-ready, 3 sleep, 4 power-off, 5..7 none |
| state_o | output | 2 | Current phase |
| pwr_en_o | output | 1 | Power switch enable |
| clk_en_o | output | 1 | Clock gate enable |

## Verification
The bench builds the block with the default 3-bit event width. With that width, all eight event codes, including the three unused ones, can be applied in each of the four phases, and the bench sweeps all 32 state-event pairs exhaustively. A long random event stream then runs against an arithmetic step model. This stream covers repeated trips around the ring, as well as runs of ignored events in every phase.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'b00,
    PS_RAMP  = 2'b01,
    PS_RUN   = 2'b10,
    PS_PARK  = 2'b11
  } pstate_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_PWR_ON,
    EV_RAIL_OK,
    EV_SLEEP,
    EV_PWR_OFF
  } evt_e;
endpackage

// File: rtl/pgs_evt_decode.sv
module pgs_evt_decode import pgs_pkg::*; #(
  parameter int EVT_W = 3
) (
  input  logic [EVT_W-1:0] code_i,
  output evt_e             evt_o
);
  always_comb begin
    if (code_i == EVT_W'(1))      evt_o = EV_PWR_ON;
    else if (code_i == EVT_W'(2)) evt_o = EV_RAIL_OK;
    else if (code_i == EVT_W'(3)) evt_o = EV_SLEEP;
    else if (code_i == EVT_W'(4)) evt_o = EV_PWR_OFF;
    else                          evt_o = EV_NONE; // unused codes fold to none
  end
endmodule

// File: rtl/pgs_next_state.sv
module pgs_next_state import pgs_pkg::*; (
  input  pstate_e state_i,
  input  evt_e    evt_i,
  output pstate_e next_o
);
  always_comb begin
    next_o = state_i;
    unique case (state_i)
      PS_OFF:  if (evt_i == EV_PWR_ON)  next_o = PS_RAMP;
      PS_RAMP: if (evt_i == EV_RAIL_OK) next_o = PS_RUN;
      PS_RUN:  if (evt_i == EV_SLEEP)   next_o = PS_PARK;
      PS_PARK: if (evt_i == EV_PWR_OFF) next_o = PS_OFF;
      default: next_o = PS_OFF;
    endcase
  end
endmodule

// File: rtl/pgs_out_decode.sv
module pgs_out_decode import pgs_pkg::*; (
  input  pstate_e state_i,
  output logic    pwr_en_o,
  output logic    clk_en_o
);
  always_comb begin
    pwr_en_o = (state_i != PS_OFF);
    clk_en_o = (state_i == PS_RUN);
  end
endmodule

// File: rtl/pgs_seq.sv
module pgs_seq import pgs_pkg::*; #(
  parameter int EVT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  output logic [1:0]       state_o,
  output logic             pwr_en_o,
  output logic             clk_en_o
);
  evt_e    evt_d;
  pstate_e state_q, state_d;

  pgs_evt_decode #(.EVT_W(EVT_W)) u_evt (
    .code_i (evt_i),
    .evt_o  (evt_d)
  );

  pgs_next_state u_nxt (
    .state_i (state_q),
    .evt_i   (evt_d),
    .next_o  (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_OFF;
    else         state_q <= state_d;
  end

  // enables decoded from the register only, so they move in lockstep
  pgs_out_decode u_out (
    .state_i  (state_q),
    .pwr_en_o (pwr_en_o),
    .clk_en_o (clk_en_o)
  );

  assign state_o = state_q;
endmodule

// File: rtl/pgs_chk.sv
module pgs_chk #(
  parameter int EVT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [EVT_W-1:0] evt_i,
  input logic [1:0]       state_o,
  input logic             pwr_en_o,
  input logic             clk_en_o
);
  // R8
  no_clk_unpowered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> !clk_en_o);

  // R3
  clk_only_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> (state_o == 2'b10));

  // R2
  pwr_off_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> (state_o == 2'b00));

  // R4
  power_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && evt_i == EVT_W'(1)) |=> (state_o == 2'b01));

  // R5
  park_to_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b11 && evt_i == EVT_W'(4)) |=> (state_o == 2'b00));

  // R6
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && evt_i != EVT_W'(3)) |=> (state_o == 2'b10));

  // R6
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b11 && evt_i != EVT_W'(4)) |=> (state_o == 2'b11));

  // R7
  unused_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i >= EVT_W'(5)) |=> $stable(state_o));
endmodule

bind pgs_seq pgs_chk #(.EVT_W(EVT_W)) u_pgs_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .state_o  (state_o),
  .pwr_en_o (pwr_en_o),
  .clk_en_o (clk_en_o)
);

// File: tb/tb_pgs_seq.sv
`timescale 1ns/1ps
module tb_pgs_seq;
  localparam int EVT_W = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [EVT_W-1:0] evt_i = '0;
  logic [1:0]       state_o;
  logic             pwr_en_o, clk_en_o;

  int checks = 0;
  int fails  = 0;
  int model  = 0;

  always #2.5 clk_i = ~clk_i;

  pgs_seq #(.EVT_W(EVT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
    .state_o(state_o), .pwr_en_o(pwr_en_o), .clk_en_o(clk_en_o)
  );

  function automatic int step(int s, int e);
    if (s == 0 && e == 1) return 1;
    if (s == 1 && e == 2) return 2;
    if (s == 2 && e == 3) return 3;
    if (s == 3 && e == 4) return 0;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compares state and both enables against the model state
  task automatic check_all(string req);
    check(req, int'(state_o), model);
    check({req, "/R2"}, int'(pwr_en_o), (model != 0) ? 1 : 0);
    check({req, "/R3"}, int'(clk_en_o), (model == 2) ? 1 : 0);
    check({req, "/R8"}, int'(!pwr_en_o && clk_en_o), 0);
  endtask

  // called at a negedge; result is sampled at the following negedge
  task automatic apply(int e);
    evt_i = EVT_W'(e);
    @(negedge clk_i);
    model = step(model, e);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    evt_i  = '0;
    model  = 0;
    #1;
    check("R1 state", int'(state_o), 0);
    check("R1 pwr", int'(pwr_en_o), 0);
    check("R1 clk", int'(clk_en_o), 0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    check_all("R1");

    // R4 R5 R9: one full lap, checking each encoding
    apply(1); check_all("R4 off->ramp");
    apply(2); check_all("R4 ramp->run");
    apply(3); check_all("R5 run->park");
    apply(4); check_all("R5 park->off");

    // R6 R7: exhaustive sweep of every state with every code
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 8; e++) begin
        do_reset();
        for (int k = 1; k <= s; k++) apply(k);
        check_all("R9 setup");
        apply(e);
        if (e >= 5)                            check_all("R7");
        else if (step(s, e) == s)              check_all("R6");
        else if (s < 2)                        check_all("R4");
        else                                   check_all("R5");
      end
    end

    // R6: parked must not go back to running; running must not jump off
    do_reset();
    apply(1); apply(2); apply(4); check_all("R6 run no off");
    apply(3); apply(2); apply(1); check_all("R6 park no run");

    // random stream against the model
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      apply(int'($urandom_range(0, 7)));
      check_all("R6 random");
    end

    // R1: reset in the middle of running
    apply(0);
    while (model != 2) apply(model + 1);
    do_reset();
    check_all("R1 mid-run");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule